// File: doc/BRIEF.md
# Bit-Serial Unsigned Adder

This block adds two unsigned operands of `WIDTH` bits by working through them one bit pair per clock, least significant bit first. Both operands are captured in parallel into shift registers that move one place to the right each step. The two low bits feed a carry controller, and each sum bit it produces enters the top end of a result register, so the finished sum appears there in parallel. The carry that leaves the top bit is reported on its own output.

The carry controller is chosen at build time. With `STYLE = CTRL_MEALY` it is a two-state machine holding only the carry, and the sum bit is formed from that state and the current inputs. With `STYLE = CTRL_MOORE` it is a four-state machine holding both the carry and the sum bit, so the sum bit it outputs is one clock late. The sequencer runs one extra step to collect that final late bit. It also skips the meaningless bit that comes out on the first step.

To use the block, pulse `load_en` with the operands on `opnd_a` and `opnd_b` while it is not busy, then pulse `start`. Wait for `done`. The operands are consumed by the addition, so each new addition needs a new load.

Top module: `serial_adder_top`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is `done`=0, `sum_out`=0 and `carry_out`=0, whatever `load_en` and `start` are.
- R2: A `load_en` pulse accepted while the block is not running captures both operands and, at the same edge, clears `sum_out` to 0 and `done` to 0.
- R3: After a start, `sum_out` holds (`opnd_a` + `opnd_b`) modulo 2^WIDTH when `done` rises. Bit pairs are added from bit 0 upward, and the first pair sees a carry-in of 0.
- R4: While `done` is high, `carry_out` equals bit WIDTH of the full sum `opnd_a` + `opnd_b`. It is 0 while `done` is low.
- R5: `done` rises WIDTH clock edges after the edge that accepts `start` when the build is Mealy, and WIDTH+1 edges after it when the build is Moore. In the Moore build, the controller's sum bit for a given bit pair appears one cycle after that pair is presented.
- R6: Once `done` is high, `done`, `sum_out` and `carry_out` stay unchanged until a `load_en` or `start` pulse is accepted.
- R7: A `start` pulse that arrives while an addition is running is ignored. It changes neither the result nor the edge at which `done` rises.
- R8: A `load_en` pulse that arrives while an addition is running is ignored. It changes neither the result nor the completion timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Capture operands and clear the result (only when not running) |
| opnd_a | input | WIDTH | Operand A, unsigned |
| opnd_b | input | WIDTH | Operand B, unsigned |
| start | input | 1 | Begin an addition (only when not running) |
| done | output | 1 | The addition is complete and the result is valid |
| sum_out | output | WIDTH | Sum modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the top bit, valid while `done` is high |

## Verification
The bench drives one stimulus into a Mealy build and a Moore build side by side. It tries all-zero operands, all-ones operands, complementary and equal alternating patterns, a maximum-plus-one case, and a random set. The all-ones and maximum-plus-one cases make the carry ripple through every bit and set the carry-out. The alternating patterns separate the sum path from the carry path, because they either produce no carry at all or a carry at every other bit. The two builds are timed against their own latencies, which shows that the Moore build's extra cycle is absorbed correctly. Runs that receive stray start or load pulses partway through confirm that the result and the timing are untouched.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

    typedef enum logic {
        CTRL_MEALY = 1'b0,
        CTRL_MOORE = 1'b1
    } ctrl_style_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'b00,
        SEQ_RUN  = 2'b01,
        SEQ_DONE = 2'b10
    } seq_state_e;

    // two-state controller: carry only
    typedef enum logic {
        CY_CLR = 1'b0,
        CY_SET = 1'b1
    } mealy_st_e;

    // four-state controller: bit 1 = carry, bit 0 = pending sum bit
    typedef enum logic [1:0] {
        MO_C0S0 = 2'b00,
        MO_C0S1 = 2'b01,
        MO_C1S0 = 2'b10,
        MO_C1S1 = 2'b11
    } moore_st_e;

    typedef struct packed {
        logic a;
        logic b;
    } bit_pair_t;

    function automatic logic fa_sum(input logic a, input logic b, input logic c);
        return a ^ b ^ c;
    endfunction

    function automatic logic fa_carry(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/sadd_opnd_sreg.sv
module sadd_opnd_sreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift,
    output logic             lsb
);
    logic [WIDTH-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {1'b0, q[WIDTH-1:1]};
        end
    end

    assign lsb = q[0];
endmodule

// File: rtl/sadd_sum_sreg.sv
module sadd_sum_sreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             shift,
    input  logic             din,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (shift) begin
            q <= {din, q[WIDTH-1:1]};
        end
    end
endmodule

// File: rtl/sadd_carry_ctrl.sv
module sadd_carry_ctrl
    import sadd_pkg::*;
#(
    parameter ctrl_style_e STYLE = CTRL_MEALY
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      adv,
    input  bit_pair_t pair,
    output logic      s,
    output logic      carry
);
    generate
        if (STYLE == CTRL_MOORE) begin : g_moore
            moore_st_e st;

            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    st <= MO_C0S0;
                end else if (adv) begin
                    st <= moore_st_e'({fa_carry(pair.a, pair.b, st[1]),
                                       fa_sum(pair.a, pair.b, st[1])});
                end
            end

            assign s     = st[0];
            assign carry = st[1];

            // R5
            moore_delay_chk: assert property (@(posedge clk) disable iff (rst)
                adv |=> (s == $past(fa_sum(pair.a, pair.b, carry))));
        end else begin : g_mealy
            mealy_st_e st;

            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    st <= CY_CLR;
                end else if (adv) begin
                    st <= mealy_st_e'(fa_carry(pair.a, pair.b, st == CY_SET));
                end
            end

            assign carry = (st == CY_SET);
            assign s     = fa_sum(pair.a, pair.b, carry);
        end
    endgenerate

    // R3
    carry_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !carry);

    // R6
    carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!adv && !clr) |=> $stable(carry));
endmodule

// File: rtl/sadd_seq.sv
module sadd_seq
    import sadd_pkg::*;
#(
    parameter int OPS   = 8,
    parameter int DELAY = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic start,
    output logic ld_acc,
    output logic clr,
    output logic adv,
    output logic cap,
    output logic busy,
    output logic done
);
    localparam int RUN_LEN = OPS + DELAY;
    localparam int CW      = $clog2(RUN_LEN + 1);

    seq_state_e    st;
    logic [CW-1:0] cnt;
    logic          st_acc;
    logic          last;

    assign busy   = (st == SEQ_RUN);
    assign done   = (st == SEQ_DONE);
    assign ld_acc = load && !busy;
    assign st_acc = start && !busy;
    assign clr    = st_acc && !ld_acc;
    assign last   = (cnt == CW'(RUN_LEN - 1));
    assign adv    = busy && (cnt < CW'(OPS));

    generate
        if (DELAY == 0) begin : g_nodelay
            assign cap = adv;
        end else begin : g_delay
            assign cap = busy && (cnt != '0);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SEQ_IDLE;
            cnt <= '0;
        end else if (ld_acc) begin
            st  <= SEQ_IDLE;
            cnt <= '0;
        end else if (st_acc) begin
            st  <= SEQ_RUN;
            cnt <= '0;
        end else if (busy) begin
            if (last) begin
                st <= SEQ_DONE;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !last) |=> (busy && cnt == $past(cnt) + 1'b1));

    // R8
    load_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && load && !last) |=> busy);

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !load && !start) |=> done);

    // R5
    run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < CW'(RUN_LEN)));
endmodule

// File: rtl/serial_adder_top.sv
module serial_adder_top
    import sadd_pkg::*;
#(
    parameter int          WIDTH = 8,
    parameter ctrl_style_e STYLE = CTRL_MEALY
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             start,
    output logic             done,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);
    localparam int DELAY = (STYLE == CTRL_MOORE) ? 1 : 0;

    logic      ld_acc, clr, adv, cap, busy;
    logic      sbit, carry;
    bit_pair_t pair;

    sadd_seq #(.OPS(WIDTH), .DELAY(DELAY)) u_seq (
        .clk(clk), .rst(rst), .load(load_en), .start(start),
        .ld_acc(ld_acc), .clr(clr), .adv(adv), .cap(cap),
        .busy(busy), .done(done)
    );

    sadd_opnd_sreg #(.WIDTH(WIDTH)) u_opa (
        .clk(clk), .rst(rst), .load(ld_acc), .load_val(opnd_a),
        .shift(adv), .lsb(pair.a)
    );

    sadd_opnd_sreg #(.WIDTH(WIDTH)) u_opb (
        .clk(clk), .rst(rst), .load(ld_acc), .load_val(opnd_b),
        .shift(adv), .lsb(pair.b)
    );

    sadd_carry_ctrl #(.STYLE(STYLE)) u_ctrl (
        .clk(clk), .rst(rst), .clr(clr), .adv(adv), .pair(pair),
        .s(sbit), .carry(carry)
    );

    sadd_sum_sreg #(.WIDTH(WIDTH)) u_sum (
        .clk(clk), .rst(rst), .clr(ld_acc), .shift(cap), .din(sbit),
        .q(sum_out)
    );

    assign carry_out = done & carry;

    // R6
    sum_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !load_en && !start) |=> ($stable(sum_out) && $stable(carry_out)));

    // R2
    load_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (load_en && !busy) |=> (sum_out == '0 && !done));

    // R4
    carry_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> !carry_out);
endmodule

// File: tb/tb_serial_adder_top.sv
`timescale 1ns/1ps
module tb_serial_adder_top;
    import sadd_pkg::*;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst, load_en, start;
    logic [W-1:0] opa, opb;
    logic         done_e, cout_e, done_o, cout_o;
    logic [W-1:0] sum_e, sum_o;

    always #2 clk = ~clk;

    serial_adder_top #(.WIDTH(W), .STYLE(CTRL_MEALY)) dut (
        .clk(clk), .rst(rst), .load_en(load_en), .opnd_a(opa), .opnd_b(opb),
        .start(start), .done(done_e), .sum_out(sum_e), .carry_out(cout_e)
    );

    serial_adder_top #(.WIDTH(W), .STYLE(CTRL_MOORE)) dut_moore (
        .clk(clk), .rst(rst), .load_en(load_en), .opnd_a(opa), .opnd_b(opb),
        .start(start), .done(done_o), .sum_out(sum_o), .carry_out(cout_o)
    );

    int    errors = 0;
    int    checks = 0;
    longint cyc   = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [W-1:0] sum;
        logic         cout;
        longint       st;
        string        tag;
    } exp_t;

    exp_t q_e[$];
    exp_t q_o[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare(input exp_t e, input logic [W-1:0] s, input logic c,
                           input longint lat, input string nm);
        check(s == e.sum, "R3", {nm, " sum ", e.tag}, s, e.sum);
        check(c == e.cout, "R4", {nm, " carry ", e.tag}, c, e.cout);
        check(cyc - e.st - 1 == lat, "R5", {nm, " latency ", e.tag}, cyc - e.st - 1, lat);
    endtask

    // monitors: pop expected items when done rises
    logic pe = 1'b0;
    logic po = 1'b0;
    always @(negedge clk) begin
        if (done_e && !pe) begin
            if (q_e.size() == 0) check(1'b0, "R6", "mealy done without start", 1, 0);
            else compare(q_e.pop_front(), sum_e, cout_e, W, "mealy");
        end
        if (done_o && !po) begin
            if (q_o.size() == 0) check(1'b0, "R6", "moore done without start", 1, 0);
            else compare(q_o.pop_front(), sum_o, cout_o, W + 1, "moore");
        end
        pe <= done_e;
        po <= done_o;
    end

    // driver: disturb 0 = clean, 1 = stray start (R7), 2 = stray load (R8)
    task automatic add(input logic [W-1:0] a, input logic [W-1:0] b,
                       input string tag, input int disturb);
        exp_t        e;
        logic [W:0]  full;
        full = {1'b0, a} + {1'b0, b};
        @(negedge clk);
        load_en = 1'b1; opa = a; opb = b;
        @(negedge clk);
        load_en = 1'b0;
        check(!done_e && !done_o && sum_e == '0 && sum_o == '0, "R2",
              {"load clears ", tag}, {done_e, done_o, sum_e | sum_o}, 0);
        start = 1'b1;
        e.sum = full[W-1:0]; e.cout = full[W]; e.st = cyc; e.tag = tag;
        q_e.push_back(e);
        q_o.push_back(e);
        @(negedge clk);
        start = 1'b0;
        if (disturb != 0) begin
            repeat (2) @(negedge clk);
            if (disturb == 1) start = 1'b1;
            else begin load_en = 1'b1; opa = ~a; opb = 8'h5A; end
            @(negedge clk);
            start = 1'b0; load_en = 1'b0;
        end
        for (int i = 0; i < 4 * W && !(done_e && done_o); i++) @(negedge clk);
        check(done_e && done_o, "R5", {"completion ", tag}, {done_e, done_o}, 3);
        repeat (3) @(negedge clk);
        check(done_e && sum_e == full[W-1:0] && cout_e == full[W], "R6",
              {"mealy hold ", tag}, {cout_e, sum_e}, full);
        check(done_o && sum_o == full[W-1:0] && cout_o == full[W], "R6",
              {"moore hold ", tag}, {cout_o, sum_o}, full);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R5 watchdog expired: actual=%0d expected=0", cyc);
        finish_run();
    end

    initial begin
        rst = 1'b1; load_en = 1'b1; start = 1'b1; opa = 8'hC3; opb = 8'h7E;
        repeat (3) @(negedge clk);
        // R1: reset wins over load and start
        check(!done_e && !done_o && sum_e == '0 && sum_o == '0 && !cout_e && !cout_o,
              "R1", "reset state", {done_e, done_o, cout_e, cout_o, sum_e | sum_o}, 0);
        rst = 1'b0; load_en = 1'b0; start = 1'b0;
        @(negedge clk);
        check(!done_e && !done_o, "R1", "idle after reset", {done_e, done_o}, 0);

        add(8'h00, 8'h00, "zeros", 0);
        add(8'hFF, 8'hFF, "ones", 0);
        add(8'hAA, 8'h55, "alt-compl", 0);
        add(8'h55, 8'h55, "alt-equal", 0);
        add(8'hAA, 8'hAA, "alt-high", 0);
        add(8'hFF, 8'h01, "max+1", 0);
        add(8'h80, 8'h80, "msb-carry", 0);
        add(8'h3C, 8'h0F, "R7 stray start", 1);
        add(8'hF0, 8'h1F, "R8 stray load", 2);
        for (int k = 0; k < 30; k++) begin
            add(W'($urandom), W'($urandom), "random", 0);
        end
        repeat (2) @(negedge clk);
        check(q_e.size() == 0 && q_o.size() == 0, "R3", "all results seen",
              q_e.size() + q_o.size(), 0);
        finish_run();
    end
endmodule